// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit integer core goes next. It holds the program counter in a register. From that PC, the current instruction word and the two source register values, it works out the following PC for the six conditional branches, the direct jump-and-link, the register-indirect jump-and-link and add-upper-immediate-to-PC. It also produces the link or result write for the destination register: a write enable, the register index and the value to write.

Branch and jump offsets are spread across several fields of the instruction word. The block gathers them back into signed offsets and adds them to the PC. The indirect jump computes its target from a register and an immediate. If bit 1 of that target is set, the block raises a misalignment flag and does not move. The PC register advances to the computed next PC on each clock edge where `step_en` is high. Reset loads it with a parameterised vector.

Top module: `brj_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is RESET_VEC (default 0x00000000). The reset is asynchronous.
- R2: On a rising clock edge with `step_en` high, `pc_q` takes the value `next_pc` had before the edge. With `step_en` low, `pc_q` holds its value.
- R3: For opcode bits [6:0] = 1100011, bits [14:12] choose the test of rs1 against rs2. The codes are: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. When the test holds, `next_pc` is PC plus the branch offset. Otherwise it is PC+4. Codes 010 and 011 never take the branch. A branch never writes a register.
- R4: The branch offset is a sign-extended 13-bit value with bit 0 zero. Its bit 12 comes from instruction bit 31, bits 10:5 from bits 30:25, bits 4:1 from bits 11:8, and bit 11 from bit 7.
- R5: For opcode 1101111, `next_pc` is PC plus the jump offset, and the value written is PC+4. The jump offset is a sign-extended 21-bit value with bit 0 zero. Its bit 20 comes from instruction bit 31, bits 10:1 from bits 30:21, bit 11 from bit 20, and bits 19:12 from bits 19:12.
- R6: For opcode 1100111 with bits [14:12] = 000, the target is rs1 plus the sign extension of instruction bits 31:20. `next_pc` is this target with bit 0 cleared, and the value written is PC+4.
- R7: If bit 1 of that indirect target is set, `misalign_exc` is 1, `next_pc` equals the current PC and `rd_we` is 0. `misalign_exc` is 0 for every other instruction.
- R8: For opcode 0010111, the value written is PC plus instruction bits 31:12 shifted left by 12, and `next_pc` is PC+4.
- R9: `rd_idx` is instruction bits 11:7. `rd_we` is high only for the jumps and for add-upper-immediate-to-PC, and it stays low when `rd_idx` is 0.
- R10: Any other opcode, including 1100111 with nonzero bits [14:12], gives `next_pc` = PC+4, `rd_we` = 0 and `misalign_exc` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Load `next_pc` into the PC register on this edge |
| instr | input | 32 | Current instruction word |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| pc_q | output | 32 | Current program counter |
| next_pc | output | 32 | Computed following PC |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_val | output | 32 | Value for the destination register |
| misalign_exc | output | 1 | Indirect jump target misaligned at bit 1 |

## Verification
The bench builds the unit with RESET_VEC = 0x00000100. This non-zero, word-aligned vector makes the reset load visible and distinguishable from a cleared register. It also lets negative offsets and PC wrap-around be exercised near the bottom of the address space. The bench walks a single one through every offset bit of both scrambled layouts, in both signs. It sweeps all eight comparison codes over signed and unsigned operand pairs, and crosses the low two bits of the indirect jump register with small positive and negative immediates. In this way every alignment outcome is reached from PCs that earlier jumps have moved.

// File: rtl/brj_unit.sv
module brj_unit #(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_en,
  input  logic [31:0] instr,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  output logic [31:0] pc_q,
  output logic [31:0] next_pc,
  output logic        rd_we,
  output logic [4:0]  rd_idx,
  output logic [31:0] rd_val,
  output logic        misalign_exc
);

  localparam logic [6:0] OP_JAL   = 7'b1101111;
  localparam logic [6:0] OP_JALR  = 7'b1100111;
  localparam logic [6:0] OP_BR    = 7'b1100011;
  localparam logic [6:0] OP_AUIPC = 7'b0010111;

  logic [6:0]  opc;
  logic [2:0]  f3;
  logic        is_jal, is_jalr, is_br, is_auipc;
  logic [31:0] b_off, j_off, i_off, u_off;
  logic [31:0] pc_plus4, jalr_sum;
  logic        cmp_eq, cmp_slt, cmp_ult, taken;

  assign opc      = instr[6:0];
  assign f3       = instr[14:12];
  assign is_jal   = (opc == OP_JAL);
  assign is_jalr  = (opc == OP_JALR) && (f3 == 3'b000);
  assign is_br    = (opc == OP_BR);
  assign is_auipc = (opc == OP_AUIPC);

  assign b_off = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign j_off = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
  assign i_off = {{20{instr[31]}}, instr[31:20]};
  assign u_off = {instr[31:12], 12'h000};

  assign cmp_eq  = (rs1_val == rs2_val);
  assign cmp_slt = ($signed(rs1_val) < $signed(rs2_val));
  assign cmp_ult = (rs1_val < rs2_val);

  always_comb begin
    case (f3)
      3'b000:  taken = cmp_eq;
      3'b001:  taken = !cmp_eq;
      3'b100:  taken = cmp_slt;
      3'b101:  taken = !cmp_slt;
      3'b110:  taken = cmp_ult;
      3'b111:  taken = !cmp_ult;
      default: taken = 1'b0;
    endcase
  end

  assign pc_plus4     = pc_q + 32'd4;
  assign jalr_sum     = rs1_val + i_off;
  assign misalign_exc = is_jalr && jalr_sum[1];

  always_comb begin
    next_pc = pc_plus4;
    if (is_jal)
      next_pc = pc_q + j_off;
    else if (is_jalr)
      next_pc = misalign_exc ? pc_q : {jalr_sum[31:1], 1'b0};
    else if (is_br && taken)
      next_pc = pc_q + b_off;
  end

  assign rd_idx = instr[11:7];
  assign rd_we  = (is_jal || is_jalr || is_auipc) && (rd_idx != 5'd0) && !misalign_exc;
  assign rd_val = is_auipc ? (pc_q + u_off) : pc_plus4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= RESET_VEC;
    else if (step_en)
      pc_q <= next_pc;
  end

endmodule

// File: rtl/brj_unit_chk.sv
module brj_unit_chk #(
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        step_en,
  input logic [31:0] pc_q,
  input logic [31:0] next_pc,
  input logic        rd_we,
  input logic [4:0]  rd_idx,
  input logic        misalign_exc
);

  a_r1_reset_vector: assert property (@(posedge clk) $rose(rst_n) |-> pc_q == RESET_VEC);

  a_r2_step_loads: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> pc_q == $past(next_pc));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc_q));

  a_r7_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_exc |-> next_pc == pc_q);

  a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_exc |-> !rd_we);

  a_r9_x0_never_written: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> rd_idx != 5'd0);

endmodule

bind brj_unit brj_unit_chk #(.RESET_VEC(RESET_VEC)) chk_i (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .pc_q(pc_q), .next_pc(next_pc),
  .rd_we(rd_we), .rd_idx(rd_idx), .misalign_exc(misalign_exc)
);

// File: tb/brj_unit_tb_top.sv
module brj_unit_tb_top;
  localparam logic [31:0] RV = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [31:0] instr = 32'h0000_0013;
  logic [31:0] rs1_val = '0, rs2_val = '0;
  logic [31:0] pc_q, next_pc, rd_val;
  logic        rd_we, misalign_exc;
  logic [4:0]  rd_idx;

  int errors = 0, checks = 0;
  logic [31:0] exp_pc, exp_next;

  always #4 clk = ~clk;

  brj_unit #(.RESET_VEC(RV)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .pc_q(pc_q), .next_pc(next_pc),
    .rd_we(rd_we), .rd_idx(rd_idx), .rd_val(rd_val), .misalign_exc(misalign_exc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_b(input logic [12:0] off, input logic [2:0] f);
    return {off[12], off[10:5], 5'd2, 5'd1, f, off[4:1], off[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] enc_j(input logic [20:0] off, input logic [4:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [2:0] f, input logic [4:0] rd);
    return {imm, 5'd3, f, rd, 7'b1100111};
  endfunction

  function automatic logic br_taken(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return $signed(a) >= $signed(b);
      3'd6: return a < b;
      3'd7: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = i; rs1_val = a; rs2_val = b;
    #1;
  endtask

  task automatic step(input string req);
    @(negedge clk);
    step_en = 1'b1;
    @(posedge clk);
    #1;
    step_en = 1'b0;
    exp_pc = exp_next;
    chk(req, pc_q, exp_pc);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] ops_a [6];
    logic [31:0] ops_b [6];
    logic [31:0] rs_list [5];
    logic [11:0] imm_list [6];
    ops_a = '{32'd5, 32'd5, 32'hFFFF_FFFE, 32'd3, 32'h8000_0000, 32'd0};
    ops_b = '{32'd5, 32'd9, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
    rs_list = '{32'h0000_1000, 32'h0000_1001, 32'h0000_1002, 32'h0000_1003, 32'hFFFF_F000};
    imm_list = '{12'h000, 12'h001, 12'h002, 12'h003, 12'hFFC, 12'hFFF};

    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pc", pc_q, RV);
    @(negedge clk); rst_n = 1'b1;
    exp_pc = RV;

    // R3: every comparison code over signed/unsigned operand pairs
    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 6; p++) begin
        apply(enc_b(13'h040, 3'(f)), ops_a[p], ops_b[p]);
        chk("R3 branch next_pc", next_pc,
            br_taken(3'(f), ops_a[p], ops_b[p]) ? exp_pc + 32'h40 : exp_pc + 4);
        chk("R3 branch no write", {31'd0, rd_we}, 32'd0);
      end

    // R4: walking one through branch offset, both signs
    for (int k = 1; k <= 12; k++) begin
      logic [12:0] o;
      o = 13'(1) << k;
      apply(enc_b(o, 3'd0), 32'd7, 32'd7);
      chk("R4 branch offset bit", next_pc, exp_pc + {{19{o[12]}}, o});
      o = ~o + 13'd1;
      o[0] = 1'b0;
      apply(enc_b(o, 3'd0), 32'd7, 32'd7);
      chk("R4 branch offset neg", next_pc, exp_pc + {{19{o[12]}}, o});
    end
    exp_next = exp_pc - 32'd4096;
    apply(enc_b(13'h1000, 3'd1), 32'd1, 32'd2);
    step("R2 branch step wraps");

    // R5: walking one through jump offset
    for (int k = 1; k <= 20; k++) begin
      logic [20:0] o;
      o = 21'(1) << k;
      apply(enc_j(o, 5'(k)), 32'd0, 32'd0);
      chk("R5 jal next_pc", next_pc, exp_pc + {{11{o[20]}}, o});
      chk("R5 jal link", rd_val, exp_pc + 4);
      chk("R9 jal rd_idx", {27'd0, rd_idx}, 32'(k));
      chk("R9 jal we", {31'd0, rd_we}, 32'd1);
      if (k == 9) begin
        exp_next = exp_pc + {{11{o[20]}}, o};
        step("R2 jal step");
      end
    end

    // R2: step_en low holds
    apply(enc_j(21'h000100, 5'd1), 32'd0, 32'd0);
    repeat (2) @(posedge clk);
    #1;
    chk("R2 hold without step", pc_q, exp_pc);

    // R6/R7: indirect jump alignment sweep
    foreach (rs_list[r])
      foreach (imm_list[m]) begin
        logic [31:0] t;
        t = rs_list[r] + {{20{imm_list[m][11]}}, imm_list[m]};
        apply(enc_i(imm_list[m], 3'd0, 5'd6), rs_list[r], 32'd0);
        if (t[1]) begin
          chk("R7 misalign flag", {31'd0, misalign_exc}, 32'd1);
          chk("R7 pc held", next_pc, exp_pc);
          chk("R7 no write", {31'd0, rd_we}, 32'd0);
        end else begin
          chk("R7 no flag", {31'd0, misalign_exc}, 32'd0);
          chk("R6 jalr target", next_pc, {t[31:1], 1'b0});
          chk("R6 jalr link", rd_val, exp_pc + 4);
          chk("R6 jalr we", {31'd0, rd_we}, 32'd1);
        end
      end
    apply(enc_i(12'h002, 3'd0, 5'd6), 32'h0000_2000, 32'd0);
    exp_next = exp_pc;
    step("R7 misaligned step keeps pc");
    apply(enc_i(12'h001, 3'd0, 5'd6), 32'h0000_2000, 32'd0);
    exp_next = 32'h0000_2000;
    step("R6 jalr step");

    // R10: indirect jump with nonzero code and foreign opcodes
    apply(enc_i(12'h002, 3'd1, 5'd6), 32'h0000_3000, 32'd0);
    chk("R10 bad jalr next_pc", next_pc, exp_pc + 4);
    chk("R10 bad jalr flags", {30'd0, rd_we, misalign_exc}, 32'd0);
    apply(32'h0020_8093, 32'd1, 32'd2);
    chk("R10 other next_pc", next_pc, exp_pc + 4);
    chk("R10 other flags", {30'd0, rd_we, misalign_exc}, 32'd0);

    // R8: upper-immediate walk
    for (int k = 0; k < 20; k++) begin
      logic [19:0] u;
      u = 20'(1) << k;
      apply({u, 5'd10, 7'b0010111}, 32'd0, 32'd0);
      chk("R8 auipc value", rd_val, exp_pc + {u, 12'h000});
      chk("R8 auipc next_pc", next_pc, exp_pc + 4);
      chk("R8 auipc we", {31'd0, rd_we}, 32'd1);
    end

    // R9: index 0 suppresses every write
    apply(enc_j(21'h000010, 5'd0), 32'd0, 32'd0);
    chk("R9 jal x0", {31'd0, rd_we}, 32'd0);
    apply(enc_i(12'h000, 3'd0, 5'd0), 32'h0000_4000, 32'd0);
    chk("R9 jalr x0", {31'd0, rd_we}, 32'd0);
    apply({20'hABCDE, 5'd0, 7'b0010111}, 32'd0, 32'd0);
    chk("R9 auipc x0", {31'd0, rd_we}, 32'd0);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 async reset", pc_q, RV);
    @(negedge clk); rst_n = 1'b1;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule